// File: doc/BRIEF.md
# Token-Counting Block Permission Tracker

This block decides, for a small set of cache blocks, which cores may read and which may write each block. Every block owns a fixed number of tokens. A token sits either in a per-block home pool or with one of the cores. A core with at least one token of a block may read that block. A core with every token of a block may write it. Permission is never stored as an encoded state. It always follows from the token counts, so a writer cannot share a block with any other reader or writer.

Each cycle, a core may issue one request on a single request port. A read request obtains one token. A write request collects all tokens of the block. A return request hands tokens back to the pool. The tracker moves the tokens at the clock edge that accepts the request. It answers one cycle later with the operation, the core and an accept flag. The read and write permission vectors for every block and core are driven directly from the stored counts. A conservation flag rises if any block's token total ever drifts from the fixed amount.

The number of cores, the tokens per block and the number of blocks are parameters. The token count must be at least the core count.

Top module: `tok_perm_tracker`

## Requirements
- R1: After reset, every token of every block is in the home pool, and no core has read or write permission on any block.
- R2: A core has read permission on a block exactly when it holds at least one of its tokens. It has write permission exactly when it holds all TOKENS of them. A write permission is never present alongside any other core's read permission on the same block.
- R3: A read request (req_op = 1) from a core that holds no token of the block moves one token from the pool to that core whenever the pool is not empty.
- R4: When the pool of the block is empty, a read request from a core without tokens takes one token from the core that holds the most. If that core was the writer, it loses write permission.
- R5: A read request from a core that already holds a token leaves every count unchanged and is accepted.
- R6: A write request (req_op = 2) moves every token of the block, from the pool and from all other cores, to the requester. It is accepted, and the requester has write permission from the cycle of the response onward.
- R7: A return request (req_op = 3) with req_count = n, where 1 ≤ n ≤ tokens held, lowers the core's holding by n and adds n to the pool at the same edge. req_count = 0 returns everything the core holds.
- R8: A return request with req_count larger than the core's holding is rejected (rsp_ok = 0) and changes no count.
- R9: Every accepted request cycle produces exactly one response in the following cycle. The response carries the request's op and core, and rsp_ok = 1 for reads and writes. No response appears without a request.
- R10: A request addressed to one block never changes the tokens or permissions of any other block.
- R11: For every block, the core holdings plus the pool always equal TOKENS, and sum_err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 1 read, 2 write, 3 return, 0 none |
| req_core | input | CORE_W | Requesting core |
| req_block | input | BLK_W | Target block |
| req_count | input | CW | Tokens to return (0 = all) |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 2 | Op of the answered request |
| rsp_core | output | CORE_W | Core of the answered request |
| rsp_ok | output | 1 | Request accepted |
| can_read | output | NUM_BLOCKS*NUM_CORES | Read permission, bit block*NUM_CORES+core |
| can_write | output | NUM_BLOCKS*NUM_CORES | Write permission, same layout |
| sum_err | output | 1 | Token total mismatch in some block |

## Verification
Reads are tried first against a full pool. They are then repeated by a core that already holds a token, which separates the pool path from the no-change path. After a write has drained the pool, reads from empty cores show whether tokens come from the largest holder and whether the writer loses write permission. Returns of an exact count, an oversized count and a count of zero separate partial return, rejection and return-all. The oversized probes also confirm the hidden counts that the earlier steps left behind. All traffic goes to one block while the other is watched, which exposes any cross-block leak.

// File: rtl/tok_pkg.sv
package tok_pkg;
   typedef enum logic [1:0] {
      TK_IDLE   = 2'd0,
      TK_READ   = 2'd1,
      TK_WRITE  = 2'd2,
      TK_RETURN = 2'd3
   } tok_op_e;
endpackage

// File: rtl/tok_max_pick.sv
module tok_max_pick #(
   parameter int NUM_CORES = 4,
   parameter int CW        = 3
) (
   input  logic [NUM_CORES*CW-1:0]         counts,
   output logic [$clog2(NUM_CORES)-1:0]    idx
);
   localparam int CORE_W = $clog2(NUM_CORES);

   logic [CW-1:0] best;

   // strict compare keeps the lowest index on equal counts
   always_comb begin
      best = '0;
      idx  = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (counts[i*CW +: CW] > best) begin
            best = counts[i*CW +: CW];
            idx  = CORE_W'(i);
         end
      end
   end
endmodule

// File: rtl/tok_block_ctrl.sv
module tok_block_ctrl
   import tok_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int TOKENS    = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  tok_op_e                          op,
   input  logic [$clog2(NUM_CORES)-1:0]     core,
   input  logic [$clog2(TOKENS+1)-1:0]      amt_in,
   output logic                             ok,
   output logic [NUM_CORES-1:0]             rd,
   output logic [NUM_CORES-1:0]             wr,
   output logic                             sum_err
);
   localparam int CORE_W = $clog2(NUM_CORES);
   localparam int CW     = $clog2(TOKENS+1);
   localparam int SW     = $clog2(TOKENS*(NUM_CORES+1)+1);

   logic [CW-1:0] held_q [NUM_CORES];
   logic [CW-1:0] held_d [NUM_CORES];
   logic [CW-1:0] pool_q, pool_d;
   logic [NUM_CORES*CW-1:0] held_flat;
   logic [CORE_W-1:0] victim;
   logic [CW-1:0] own, take;
   logic [SW-1:0] total;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign held_flat[c*CW +: CW] = held_q[c];
      assign rd[c] = (held_q[c] != '0);
      assign wr[c] = (held_q[c] == CW'(TOKENS));
   end

   tok_max_pick #(.NUM_CORES(NUM_CORES), .CW(CW)) u_pick (
      .counts (held_flat),
      .idx    (victim)
   );

   always_comb begin
      for (int i = 0; i < NUM_CORES; i++) held_d[i] = held_q[i];
      pool_d = pool_q;
      ok     = 1'b1;
      own    = held_q[core];
      take   = (amt_in == '0) ? own : amt_in;
      if (en) begin
         case (op)
            TK_READ: begin
               if (own == '0) begin
                  if (pool_q != '0) pool_d = pool_q - 1'b1;
                  else              held_d[victim] = held_q[victim] - 1'b1;
                  held_d[core] = CW'(1);
               end
            end
            TK_WRITE: begin
               for (int i = 0; i < NUM_CORES; i++) held_d[i] = '0;
               pool_d       = '0;
               held_d[core] = CW'(TOKENS);
            end
            TK_RETURN: begin
               if (take > own) ok = 1'b0;
               else begin
                  held_d[core] = own - take;
                  pool_d       = pool_q + take;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CORES; i++) held_q[i] <= '0;
         pool_q <= CW'(TOKENS);
      end else begin
         for (int i = 0; i < NUM_CORES; i++) held_q[i] <= held_d[i];
         pool_q <= pool_d;
      end
   end

   always_comb begin
      total = SW'(pool_q);
      for (int i = 0; i < NUM_CORES; i++) total = total + SW'(held_q[i]);
   end
   assign sum_err = (total != SW'(TOKENS));

   a_r11_tokens_conserved: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_err);
   a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr) |-> ($countones(rd) == 1));
   a_r3_read_grants: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == TK_READ) |=> rd[$past(core)]);
   a_r8_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == TK_RETURN && !ok) |=> $stable(pool_q));
endmodule

// File: rtl/tok_perm_tracker.sv
module tok_perm_tracker
   import tok_pkg::*;
#(
   parameter int NUM_CORES  = 4,
   parameter int TOKENS     = 6,
   parameter int NUM_BLOCKS = 2
) (
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic                                              req_valid,
   input  logic [1:0]                                        req_op,
   input  logic [$clog2(NUM_CORES)-1:0]                      req_core,
   input  logic [((NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1)-1:0] req_block,
   input  logic [$clog2(TOKENS+1)-1:0]                       req_count,
   output logic                                              rsp_valid,
   output logic [1:0]                                        rsp_op,
   output logic [$clog2(NUM_CORES)-1:0]                      rsp_core,
   output logic                                              rsp_ok,
   output logic [NUM_BLOCKS*NUM_CORES-1:0]                   can_read,
   output logic [NUM_BLOCKS*NUM_CORES-1:0]                   can_write,
   output logic                                              sum_err
);
   localparam int CORE_W = $clog2(NUM_CORES);
   localparam int CW     = $clog2(TOKENS+1);
   localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

   if (NUM_CORES < 2)      begin : g_bad_cores  $error("NUM_CORES must be at least 2"); end
   if (TOKENS < NUM_CORES) begin : g_bad_tokens $error("TOKENS must be at least NUM_CORES"); end
   if (NUM_BLOCKS < 1)     begin : g_bad_blocks $error("NUM_BLOCKS must be at least 1"); end

   logic [NUM_BLOCKS-1:0] ok_b, err_b;
   logic [BLK_W-1:0]      rsp_blk_q;
   tok_op_e               op_in;
   int                    widx;
   logic                  rsp_wr_perm;

   assign op_in = tok_op_e'(req_op);

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      logic blk_en;
      assign blk_en = req_valid && (req_block == BLK_W'(b));
      tok_block_ctrl #(.NUM_CORES(NUM_CORES), .TOKENS(TOKENS)) u_blk (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (blk_en),
         .op      (op_in),
         .core    (req_core),
         .amt_in  (req_count),
         .ok      (ok_b[b]),
         .rd      (can_read[b*NUM_CORES +: NUM_CORES]),
         .wr      (can_write[b*NUM_CORES +: NUM_CORES]),
         .sum_err (err_b[b])
      );
   end

   assign sum_err = |err_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_op    <= '0;
         rsp_core  <= '0;
         rsp_ok    <= 1'b0;
         rsp_blk_q <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_op    <= req_op;
         rsp_core  <= req_core;
         rsp_ok    <= req_valid && ok_b[req_block];
         rsp_blk_q <= req_block;
      end
   end

   always_comb begin
      widx        = int'(rsp_blk_q) * NUM_CORES + int'(rsp_core);
      rsp_wr_perm = can_write[widx];
   end

   a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r6_writer_owns: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_op == 2'd2) |-> (rsp_ok && rsp_wr_perm));
endmodule

// File: tb/tok_perm_tracker_tb.sv
module tok_perm_tracker_tb;
   localparam int NC = 4;
   localparam int TK = 6;
   localparam int NB = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [1:0] req_core = 2'd0;
   logic [0:0] req_block = 1'b0;
   logic [2:0] req_count = 3'd0;
   logic       rsp_valid, rsp_ok, sum_err;
   logic [1:0] rsp_op, rsp_core;
   logic [NB*NC-1:0] can_read, can_write;

   int tests = 0;
   int fails = 0;

   typedef struct { int core; int op; bit ok; string tag; } exp_t;
   exp_t q[$];

   int mcnt [NB][NC];
   int mpool[NB];

   always #2 clk = ~clk;

   tok_perm_tracker #(.NUM_CORES(NC), .TOKENS(TK), .NUM_BLOCKS(NB)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_core(req_core), .req_block(req_block), .req_count(req_count),
      .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_core(rsp_core), .rsp_ok(rsp_ok),
      .can_read(can_read), .can_write(can_write), .sum_err(sum_err)
   );

   task automatic check(input bit cond, input string tag, input int act, input int exp);
      tests++;
      if (!cond) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the expected response when the design produces one
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q.size() == 0) check(1'b0, "R9 unexpected response", 1, 0);
         else begin
            exp_t e;
            e = q.pop_front();
            check(int'(rsp_core) == e.core, {e.tag, " R9 rsp_core"}, int'(rsp_core), e.core);
            check(int'(rsp_op) == e.op, {e.tag, " R9 rsp_op"}, int'(rsp_op), e.op);
            check(rsp_ok == e.ok, {e.tag, " rsp_ok"}, int'(rsp_ok), int'(e.ok));
         end
      end
   end

   task automatic check_state(input string tag);
      for (int b = 0; b < NB; b++) begin
         logic [NC-1:0] er, ew;
         for (int c = 0; c < NC; c++) begin
            er[c] = (mcnt[b][c] != 0);
            ew[c] = (mcnt[b][c] == TK);
         end
         check(can_read[b*NC +: NC] == er, {tag, " R2 can_read"}, int'(can_read[b*NC +: NC]), int'(er));
         check(can_write[b*NC +: NC] == ew, {tag, " R2 can_write"}, int'(can_write[b*NC +: NC]), int'(ew));
      end
      check(sum_err == 1'b0, {tag, " R11 sum_err"}, int'(sum_err), 0);
   endtask

   // driver: updates the model, pushes the expected response, drives one cycle
   task automatic do_req(input int op, input int core, input int blk, input int cnt, input string tag);
      exp_t e;
      bit   ok = 1'b1;
      if (op == 1) begin
         if (mcnt[blk][core] == 0) begin
            if (mpool[blk] > 0) mpool[blk]--;
            else begin
               int best = 0, bi = 0;
               for (int c = 0; c < NC; c++) if (mcnt[blk][c] > best) begin best = mcnt[blk][c]; bi = c; end
               mcnt[blk][bi]--;
            end
            mcnt[blk][core] = 1;
         end
      end else if (op == 2) begin
         for (int c = 0; c < NC; c++) mcnt[blk][c] = 0;
         mpool[blk] = 0;
         mcnt[blk][core] = TK;
      end else if (op == 3) begin
         int n = (cnt == 0) ? mcnt[blk][core] : cnt;
         if (n > mcnt[blk][core]) ok = 1'b0;
         else begin mcnt[blk][core] -= n; mpool[blk] += n; end
      end
      e.core = core; e.op = op; e.ok = ok; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_core = 2'(core);
      req_block = 1'(blk); req_count = 3'(cnt);
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'd0;
      check_state(tag);
   endtask

   initial begin
      #(200000 * 4);
      check(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int b = 0; b < NB; b++) begin
         mpool[b] = TK;
         for (int c = 0; c < NC; c++) mcnt[b][c] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 reset");
      check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

      do_req(1, 0, 0, 0, "R3 read from full pool");
      do_req(1, 1, 0, 0, "R3 second reader");
      do_req(1, 0, 0, 0, "R5 repeat read");
      do_req(2, 2, 0, 0, "R6 write collects all");
      do_req(1, 3, 0, 0, "R4 read steals from writer");
      do_req(1, 1, 0, 0, "R4 read steals again");
      do_req(3, 2, 0, 5, "R8 over-return rejected");
      do_req(3, 2, 0, 2, "R7 partial return");
      do_req(3, 3, 0, 3, "R8 over-return by single holder");
      do_req(3, 2, 0, 0, "R7 return all");
      do_req(3, 1, 0, 2, "R8 over-return after return");
      do_req(1, 2, 1, 0, "R10 other block read");
      do_req(2, 0, 1, 0, "R10 other block write");
      do_req(3, 0, 1, 0, "R7 return all other block");
      do_req(2, 1, 0, 0, "R6 write from reader");
      do_req(2, 1, 0, 0, "R6 write by owner");
      do_req(3, 1, 0, 6, "R7 return full count");
      do_req(3, 1, 0, 0, "R7 return all when empty");

      @(negedge clk);
      check(rsp_valid == 1'b0, "R9 idle no response", int'(rsp_valid), 0);
      check(q.size() == 0, "R9 all responses seen", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule